// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block controls how a clock generator goes into and comes out of its low-power state. A single active-low power-down request arrives with no timing relation to the sequencing clock. It passes through a synchroniser before any decision is made on it. Once the request is seen, the reference output is blocked at once. Each gated clock group then closes its gate, but only while that group's internal clock is low, so no shortened high pulse reaches an output. When every group is closed, the oscillator/VCO enable is removed.

When the request is released, the oscillator enable is raised first. A counter then runs for a fixed number of sequencing-clock cycles so that the analog parts can settle. After that, the block reports that power is good and opens the gates again, each one on a low phase of its clock. If the request returns during the settle count, the count is abandoned and the block goes back to the fully-off state. The per-group stop inputs are only obeyed while the block is fully powered. Group index 0 is the processor clock group and index 1 is the bus clock group.

Top module: `pwrdn_seq`

## Requirements
- R1: `pwr_dn_n` passes through SYNC_STAGES flip-flops before it acts. With the default of 2, a change in `pwr_dn_n` applied between clock edges changes the sequencer state on the third rising edge after it.
- R2: `ref_en` falls on the same edge as `pwr_good` when power-down is recognised. It does not wait on the level of any gated clock.
- R3: A `gate_en` bit changes value only on an edge where the matching `clk_lvl` bit is 0. A group whose clock is high keeps its gate open until the clock goes low.
- R4: `osc_en` falls only after every `gate_en` bit has been 0 for one edge. While any gate is still open, `osc_en` stays 1.
- R5: The block is fully off and power-down is released. Then `osc_en` rises when the release is recognised (edge 3 with default SYNC_STAGES). `pwr_good` and `ref_en` rise SETTLE_CYCLES edges later.
- R6: A `gate_en` bit opens only on an edge after `pwr_good` is 1, and only when its `clk_lvl` bit is 0.
- R7: If power-down is recognised during the settle count, `osc_en` falls on that edge and `pwr_good` stays 0. A later release restarts the full SETTLE_CYCLES count.
- R8: While `pwr_good` is 1, a 0 on `stop_n[i]` closes `gate_en[i]` on a low phase of `clk_lvl[i]`. While `pwr_good` is 0, `stop_n` has no effect on any output.
- R9: Asynchronous reset puts all outputs to 0 and treats power-down as asserted. The block therefore begins with the settle sequence once `pwr_dn_n` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down request |
| clk_lvl | input | NGRP | Present level of each group's internal clock |
| stop_n | input | NGRP | Active-low per-group stop request (0 = processor group, 1 = bus group) |
| osc_en | output | 1 | Oscillator/VCO enable |
| gate_en | output | NGRP | Per-group output gate enable |
| ref_en | output | 1 | Reference output enable; 0 forces the reference low |
| pwr_good | output | 1 | Fully powered up and outputs valid |

## Verification
The bench builds the block with SETTLE_CYCLES = 5 and SYNC_STAGES = 2 and keeps the default two clock groups. With this short settle count, the bench can land a re-assertion in the middle of the count and see a full restart of the count, all within a few dozen cycles. It can also check edge by edge the exact cycle on which the count ends. With two groups, the bench can hold one group's clock high while the other's is low. This shows a gate held open by a high phase while the reference output is already off.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_RUN    = 2'd2,
        SEQ_DRAIN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/pds_sync.sv
module pds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    // Reset value 0: a request to power down is assumed until proven otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pds_gate.sv
module pds_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic want,
    output logic en
);
    logic en_d, en_q;

    // Gate state may only move while the clock it guards is low
    always_comb begin
        en_d = en_q;
        if (!lvl) en_d = want;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    AST_GATE_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != $past(en_q)) |-> !$past(lvl)); // R3

endmodule

// File: rtl/pds_settle_ctr.sv
module pds_settle_ctr #(
    parameter int SETTLE_CYCLES = 43000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (SETTLE_CYCLES > 2) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R5
    AST_CNT_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> cnt_q == '0); // R7

endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
    import pwrdn_seq_pkg::*;
#(
    parameter int NGRP          = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 43000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_dn_n,
    input  logic [NGRP-1:0] clk_lvl,
    input  logic [NGRP-1:0] stop_n,
    output logic            osc_en,
    output logic [NGRP-1:0] gate_en,
    output logic            ref_en,
    output logic            pwr_good
);
    seq_regs_t r_d, r_q;
    logic      up_req;
    logic      settle_done;
    logic      running;
    logic      all_closed;

    pds_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwr_dn_n),
        .sync_out (up_req)
    );

    pds_settle_ctr #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == SEQ_SETTLE),
        .done  (settle_done)
    );

    assign running = (r_q.state == SEQ_RUN);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        pds_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (clk_lvl[g]),
            .want  (running && stop_n[g]),
            .en    (gate_en[g])
        );
    end

    assign all_closed = (gate_en == '0);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_OFF:    if (up_req) r_d.state = SEQ_SETTLE;
            SEQ_SETTLE: begin
                if (!up_req)          r_d.state = SEQ_OFF;
                else if (settle_done) r_d.state = SEQ_RUN;
            end
            SEQ_RUN:    if (!up_req) r_d.state = SEQ_DRAIN;
            SEQ_DRAIN:  if (all_closed) r_d.state = SEQ_OFF;
            default:    r_d.state = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: SEQ_OFF};
        else        r_q <= r_d;
    end

    assign osc_en   = (r_q.state != SEQ_OFF);
    assign pwr_good = running;
    assign ref_en   = running;

    AST_OSC_OFF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> ($past(gate_en) == '0)); // R4
    AST_GOOD_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> osc_en); // R5
    AST_OPEN_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gate_en & ~$past(gate_en))) |-> $past(pwr_good)); // R6
    AST_ABORT_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(osc_en) && !$past(pwr_good) && !$past(up_req) && $past(all_closed))
        |-> !pwr_good); // R7

endmodule

// File: tb/pwrdn_seq_bench.sv
module pwrdn_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NGRP = 2;
    localparam int NVEC = 23;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwr_dn_n = 1'b1;
    logic [NGRP-1:0] clk_lvl = '0;
    logic [NGRP-1:0] stop_n = '1;
    logic            osc_en, ref_en, pwr_good;
    logic [NGRP-1:0] gate_en;

    int applied = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_seq #(.NGRP(NGRP), .SYNC_STAGES(2), .SETTLE_CYCLES(5)) u_pwrdn_seq (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .clk_lvl(clk_lvl),
        .stop_n(stop_n), .osc_en(osc_en), .gate_en(gate_en),
        .ref_en(ref_en), .pwr_good(pwr_good)
    );

    // {req(4), pd_n(1), lvl(2), stop_n(2), edges(4), expect{osc,gate[1:0],ref,good}(5)}
    localparam logic [17:0] VEC [NVEC] = '{
        {4'd9, 1'b1, 2'b00, 2'b11, 4'd2, 5'b0_00_0_0}, // R9 still off while sync fills
        {4'd5, 1'b1, 2'b00, 2'b11, 4'd1, 5'b1_00_0_0}, // R5 oscillator first
        {4'd5, 1'b1, 2'b00, 2'b11, 4'd4, 5'b1_00_0_0}, // R5 counting
        {4'd5, 1'b1, 2'b00, 2'b11, 4'd1, 5'b1_00_1_1}, // R5 good after count
        {4'd6, 1'b1, 2'b00, 2'b11, 4'd1, 5'b1_11_1_1}, // R6 gates open after good
        {4'd3, 1'b1, 2'b11, 2'b10, 4'd2, 5'b1_11_1_1}, // R3 stop held off by high phase
        {4'd8, 1'b1, 2'b00, 2'b10, 4'd1, 5'b1_10_1_1}, // R8 processor group stops
        {4'd6, 1'b1, 2'b11, 2'b11, 4'd1, 5'b1_10_1_1}, // R6 no open on high phase
        {4'd6, 1'b1, 2'b00, 2'b11, 4'd1, 5'b1_11_1_1}, // R6 reopen on low phase
        {4'd1, 1'b0, 2'b01, 2'b11, 4'd2, 5'b1_11_1_1}, // R1 not yet recognised
        {4'd2, 1'b0, 2'b01, 2'b11, 4'd1, 5'b1_11_0_0}, // R2 reference off at once
        {4'd3, 1'b0, 2'b01, 2'b11, 4'd1, 5'b1_01_0_0}, // R3 low group closes only
        {4'd4, 1'b0, 2'b01, 2'b11, 4'd3, 5'b1_01_0_0}, // R4 osc held while open
        {4'd3, 1'b0, 2'b00, 2'b11, 4'd1, 5'b1_00_0_0}, // R3 last gate closes
        {4'd4, 1'b0, 2'b00, 2'b11, 4'd1, 5'b0_00_0_0}, // R4 osc off after close
        {4'd8, 1'b0, 2'b11, 2'b00, 4'd2, 5'b0_00_0_0}, // R8 stops ignored when off
        {4'd5, 1'b1, 2'b00, 2'b11, 4'd3, 5'b1_00_0_0}, // R5 release recognised
        {4'd7, 1'b0, 2'b00, 2'b11, 4'd2, 5'b1_00_0_0}, // R7 request returns mid count
        {4'd7, 1'b0, 2'b00, 2'b11, 4'd1, 5'b0_00_0_0}, // R7 aborted to off
        {4'd7, 1'b1, 2'b00, 2'b11, 4'd3, 5'b1_00_0_0}, // R7 second release
        {4'd7, 1'b1, 2'b00, 2'b11, 4'd4, 5'b1_00_0_0}, // R7 full count restarts
        {4'd7, 1'b1, 2'b00, 2'b11, 4'd1, 5'b1_00_1_1}, // R7 good after full count
        {4'd6, 1'b1, 2'b00, 2'b11, 4'd1, 5'b1_11_1_1}  // R6 gates open again
    };

    task automatic check(input int req, input logic [4:0] exp);
        logic [4:0] act;
        act = {osc_en, gate_en, ref_en, pwr_good};
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d: {osc,gate,ref,good} actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin : main
        #(CLK_PERIOD*2 + 1);
        check(9, 5'b0_00_0_0); // R9 reset state
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            pwr_dn_n = VEC[i][13];
            clk_lvl  = VEC[i][12:11];
            stop_n   = VEC[i][10:9];
            repeat (int'(VEC[i][8:5])) @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i][17:14]), VEC[i][4:0]);
        end
        // R9 reset mid-run clears everything at once
        #1 rst_n = 1'b0;
        #1 check(9, 5'b0_00_0_0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(9, 5'b0_00_0_0); // R9 restart goes through settle
        @(posedge clk);
        @(negedge clk);
        check(5, 5'b1_00_0_0); // R5 osc rises on third edge
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

endmodule